// File: doc/BRIEF.md
# Downward Step Event Counter

This block watches a small unsigned sample bus that is taken on every rising clock edge. It counts the edges at which the sample has fallen by more than a fixed margin relative to the sample taken one edge earlier. The count resets itself once the bus has been zero for three edges in a row. The count sits in a narrow register that wraps, and it is visible on the output right after the edge that caused the change.

Three small pieces sit inside. The first is a two-deep sample history. The second is a comparator that widens the sum so it cannot overflow. The third is a three-state tracker for runs of zeros. The tracker has the states ZS_NONE (the last sample was nonzero), ZS_ONE (the last sample was zero, the one before was not) and ZS_TWO (the last two samples were zero). Its transitions are named as follows. A nonzero sample moves any state to ZS_NONE. A zero sample steps ZS_NONE to ZS_ONE, steps ZS_ONE to ZS_TWO, and keeps ZS_TWO in ZS_TWO. Reset enters ZS_TWO, because the cleared history holds two zeros. A zero sample that arrives while the tracker is in ZS_TWO requests a clear.

Top module: `step_drop_counter`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the count to 0 and sets both stored history samples to 0. If the history is cleared, a first sample of 0 after reset leaves the count at 0, even when 7 was applied before the reset.
- R2: At each rising edge the count rises by one when the previous sample, read as unsigned, is strictly greater than the current sample plus 2. A drop of exactly 2 does not count.
- R3: The sum of the current sample and 2 is formed one bit wider than the sample, so it never wraps. A previous sample of 7 followed by a current sample of 6 does not count.
- R4: If the sample rises or stays the same, the count holds its value.
- R5: If the current sample and the two samples before it are all 0, the count becomes 0 at that edge. Only two consecutive zeros leave the count unchanged.
- R6: A clear request takes priority over an increment at the same edge.
- R7: The 3-bit count wraps from 7 to 0 on an increment.
- R8: The output shows the updated count directly after the rising edge at which the sample was taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_in | input | DATA_W (3) | Unsigned sample taken at each edge |
| event_count | output | CNT_W (3) | Number of qualifying drops, wrapping |

## Verification
The bench aims at the boundary of the comparison. A drop of exactly two must not count, and a drop of three must count. A design that uses greater-or-equal would count the first case. The pair 7 then 6 checks that the sum is formed wide enough: a design that wraps the sum would see 0 and count a rise. Zero runs of length two and three separate a tracker that clears one edge early from one that is correct. A run of pulses between 7 and 0 drives the count through the wrap to 0. Applying 7 just before reset, then 0 just after it, shows whether the history registers really clear: stale history would give a false count.

// File: rtl/step_mon_pkg.sv
package step_mon_pkg;

    // Zero-run tracker states: how many of the stored samples are zero
    typedef enum logic [1:0] {
        ZS_NONE = 2'd0,
        ZS_ONE  = 2'd1,
        ZS_TWO  = 2'd2
    } zrun_state_e;

endpackage

// File: rtl/smp_history.sv
module smp_history #(
    parameter int DATA_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] sample_i,
    output logic [DATA_W-1:0] prev_o,
    output logic [DATA_W-1:0] prev2_o
);

    logic [DATA_W-1:0] prev_q;
    logic [DATA_W-1:0] prev2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            prev2_q <= '0;
        end else begin
            prev_q  <= sample_i;
            prev2_q <= prev_q;
        end
    end

    assign prev_o  = prev_q;
    assign prev2_o = prev2_q;

    AST_HIST_RESET: assert property (@(posedge clk) rst |=> (prev_q == '0 && prev2_q == '0)); // R1
    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (prev_q == $past(sample_i) && prev2_q == $past(prev_q))); // R2

endmodule

// File: rtl/drop_detect.sv
module drop_detect #(
    parameter int DATA_W = 3,
    parameter int STEP   = 2
) (
    input  logic [DATA_W-1:0] prev_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              inc_o
);

    // One extra bit keeps sample + STEP from wrapping
    localparam int SUM_W = DATA_W + 1;

    logic [SUM_W-1:0] bound;
    logic [SUM_W-1:0] prev_w;

    always_comb begin
        bound  = SUM_W'(sample_i) + SUM_W'(STEP);
        prev_w = SUM_W'(prev_i);
        inc_o  = (prev_w > bound);
    end

endmodule

// File: rtl/zrun_fsm.sv
module zrun_fsm
    import step_mon_pkg::*;
#(
    parameter int DATA_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] sample_i,
    output logic              clr_o
);

    zrun_state_e state_q;
    zrun_state_e state_d;
    logic        is_zero;

    assign is_zero = (sample_i == '0);

    // State register; reset enters ZS_TWO since cleared history holds zeros
    always_ff @(posedge clk) begin
        if (rst) state_q <= ZS_TWO;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ZS_NONE: state_d = is_zero ? ZS_ONE : ZS_NONE;
            ZS_ONE:  state_d = is_zero ? ZS_TWO : ZS_NONE;
            ZS_TWO:  state_d = is_zero ? ZS_TWO : ZS_NONE;
            default: state_d = ZS_NONE;
        endcase
    end

    // Output process: third consecutive zero requests a clear
    always_comb begin
        clr_o = 1'b0;
        unique case (state_q)
            ZS_NONE: clr_o = 1'b0;
            ZS_ONE:  clr_o = 1'b0;
            ZS_TWO:  clr_o = is_zero;
            default: clr_o = 1'b0;
        endcase
    end

    AST_ZRUN_ENTER: assert property (@(posedge clk) disable iff (rst)
        (state_q == ZS_ONE && is_zero) |=> (state_q == ZS_TWO)); // R5

endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (inc_i) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    AST_CNT_RESET: assert property (@(posedge clk) rst |=> (cnt_q == '0)); // R1
    AST_CLR_WINS:  assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_q == '0)); // R6
    AST_INC_WRAP:  assert property (@(posedge clk) disable iff (rst)
        (inc_i && !clr_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R7
    AST_CNT_HOLD:  assert property (@(posedge clk) disable iff (rst)
        (!inc_i && !clr_i) |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/step_drop_counter.sv
module step_drop_counter #(
    parameter int DATA_W = 3,
    parameter int CNT_W  = 3,
    parameter int STEP   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] sample_in,
    output logic [CNT_W-1:0]  event_count
);

    logic [DATA_W-1:0] prev;
    logic [DATA_W-1:0] prev2;
    logic              step_inc;
    logic              run_clr;

    smp_history #(.DATA_W(DATA_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .sample_i (sample_in),
        .prev_o   (prev),
        .prev2_o  (prev2)
    );

    drop_detect #(.DATA_W(DATA_W), .STEP(STEP)) u_detect (
        .prev_i   (prev),
        .sample_i (sample_in),
        .inc_o    (step_inc)
    );

    zrun_fsm #(.DATA_W(DATA_W)) u_zrun (
        .clk      (clk),
        .rst      (rst),
        .sample_i (sample_in),
        .clr_o    (run_clr)
    );

    evt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr_i (run_clr),
        .inc_i (step_inc),
        .cnt_o (event_count)
    );

    // History (separate registers) against the count driven by the tracker path
    AST_ZERO_RUN: assert property (@(posedge clk) disable iff (rst)
        (sample_in == '0 && prev == '0 && prev2 == '0) |=> (event_count == '0)); // R5

endmodule

// File: tb/step_drop_counter_tb.sv
module step_drop_counter_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sample_in = 3'd0;
    logic [2:0] event_count;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    // reference state derived from the requirements
    int m_cnt = 0;
    int m_p1  = 0;
    int m_p2  = 0;

    always #10 clk = ~clk;

    step_drop_counter u_dut (
        .clk         (clk),
        .rst         (rst),
        .sample_in   (sample_in),
        .event_count (event_count)
    );

    task automatic drive(input bit r, input int v, input string tag);
        @(negedge clk);
        rst       = r;
        sample_in = v[2:0];
        if (r) begin
            m_cnt = 0; m_p1 = 0; m_p2 = 0;
        end else begin
            if (v == 0 && m_p1 == 0 && m_p2 == 0) m_cnt = 0;
            else if (m_p1 > v + 2)               m_cnt = (m_cnt + 1) % 8;
            m_p2 = m_p1;
            m_p1 = v;
        end
        exp_q.push_back(m_cnt);
        tag_q.push_back(tag);
    endtask

    // monitor: compare just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (event_count !== e[2:0]) begin
                    errors++;
                    $display("FAIL %s: event_count=%0d expected %0d", t, event_count, e);
                end
            end
        end
    end

    initial begin
        // R1 reset state
        drive(1, 5, "R1");
        drive(1, 5, "R1");
        // R4 rising and flat input
        drive(0, 1, "R4");
        drive(0, 5, "R4");
        drive(0, 7, "R4");
        drive(0, 7, "R4");
        // R2 drops of three or more count, exactly two does not
        drive(0, 4, "R2");
        drive(0, 1, "R2");
        drive(0, 6, "R4");
        drive(0, 3, "R2");
        drive(0, 1, "R2");
        // R3 7 then 6 with wide sum
        drive(0, 7, "R3");
        drive(0, 6, "R3");
        // R7 wrap through repeated 7->0 drops
        for (int i = 0; i < 5; i++) begin
            drive(0, 7, "R7");
            drive(0, 0, "R7");
        end
        // R5 zero run: two zeros keep, third clears
        drive(0, 7, "R5");
        drive(0, 4, "R5");
        drive(0, 0, "R5");
        drive(0, 0, "R5");
        drive(0, 0, "R5");
        drive(0, 0, "R5");
        // R8 single-edge latency after clear
        drive(0, 7, "R8");
        drive(0, 0, "R8");
        // R1 history cleared by reset
        drive(0, 7, "R1");
        drive(1, 7, "R1");
        drive(0, 0, "R1");
        drive(0, 0, "R1");
        @(posedge clk);
        @(posedge clk);
        #5;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run incomplete, got timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule